// File: doc/BRIEF.md
# Bank Sparse Hit Cluster Encoder

This block compresses one row of binary hit flags from a bank of column discriminators into a short list of cluster states. Each bit of the input vector belongs to one column, and a bit at 1 means that column's pixel was hit. The encoder looks for runs of neighbouring hits. Each run becomes one state: the in-bank column address of the run's first pixel, plus a 2-bit code that gives how many pixels the run holds.

A row is offered with a one-cycle valid strobe. While the encoder works it raises a busy flag, and it ignores any further strobes until it is done. It then pulses a done flag. The resulting states, their valid flags and an overflow flag stay stable on the outputs until the next row is accepted. Many such encoders can sit side by side, one per bank, and a later stage merges their results.

Top module: `hit_cluster_encoder`

## Requirements
- R1: A column produces a state only when its hit bit is 1. Every valid state's address points at a column whose hit bit is 1, and a row with no hits produces no valid state and no overflow.
- R2: The length code of a state is binary 00, 01, 10 or 11 for a run of one, two, three or four adjacent hit columns.
- R3: A state's address is the column index (0 = bit 0 of the hit vector) of the lowest-numbered column of its run. The 6-bit address field of slot s is state_addr_o[6s+5:6s].
- R4: A run longer than four columns is cut after four, and its fifth column starts a new state. The cutting repeats along the run.
- R5: States fill slots in increasing column order, starting at slot 0. The valid flags of the filled slots form a contiguous block from bit 0 upward.
- R6: At most 6 states are kept per row. When the row holds more runs than that, the states beyond the sixth are dropped and overflow_o is 1 for that row. Otherwise overflow_o is 0.
- R7: A row is accepted on a clock edge where row_valid_i is 1 and busy_o is 0. busy_o is 1 from the next cycle until the encoding completes. A strobe that arrives while busy_o is 1 is ignored and does not change the results.
- R8: done_o is a one-cycle pulse in the first cycle after busy_o falls. Results stay unchanged after it until the next row is accepted.
- R9: After reset, busy_o, done_o, overflow_o and all valid flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| row_valid_i | input | 1 | Offers hits_i as a new row |
| hits_i | input | 64 | Hit flag per column, 1 = hit |
| busy_o | output | 1 | Encoding in progress, new rows refused |
| done_o | output | 1 | One-cycle pulse when a row's results are final |
| state_valid_o | output | 6 | Valid flag per state slot |
| state_addr_o | output | 36 | Six 6-bit first-column addresses, slot s at bits 6s+5:6s |
| state_len_o | output | 12 | Six 2-bit length codes, slot s at bits 2s+1:2s |
| overflow_o | output | 1 | Row had more runs than slots |

## Verification
The assertions assume that reset is held for at least one clock edge before any row is offered. They also assume that a row strobe offered while busy is refused rather than queued, so they never relate a refused strobe to later results. The stimulus always waits for done before it offers the next row. It deliberately drives a second strobe with a different hit vector during busy, and the bench checks that this strobe leaves the results untouched. Random rows vary the hit density from sparse to dense so that both the overflow and non-overflow sides of the slot limit are reached.

// File: rtl/hce_pkg.sv
// Package: shared types of the hit cluster encoder.
// Assumes nothing beyond standard SystemVerilog.
package hce_pkg;
    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;
endpackage

// File: rtl/hce_first_hit.sv
// Module: hce_first_hit
// Finds the lowest-numbered set bit of a mask.
// Assumes W >= 2. The index output is 0 when no bit is set.
module hce_first_hit #(
    parameter int W = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask_i,
    output logic          found_o,
    output logic [IW-1:0] index_o
);
    // Priority encode, with the lowest index winning.
    always_comb begin
        found_o = |mask_i;
        index_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i]) index_o = IW'(i);
        end
    end
endmodule

// File: rtl/hce_run_len.sv
// Module: hce_run_len
// Measures the run of set bits that begins at start_i, capped at RUN_MAX.
// It returns the length minus one and a mask of the columns that the run used.
// Assumes that mask_i[start_i] is 1 (start_i is the lowest set bit).
module hce_run_len #(
    parameter int W       = 64,
    parameter int RUN_MAX = 4,
    localparam int IW = $clog2(W),
    localparam int LW = $clog2(RUN_MAX)
) (
    input  logic [W-1:0]  mask_i,
    input  logic [IW-1:0] start_i,
    output logic [LW-1:0] len_code_o,
    output logic [W-1:0]  used_o
);
    logic [W-1:0]       shifted;
    logic [RUN_MAX-1:0] run_bits;
    logic               cont;
    logic [LW:0]        count;

    // Walk up to RUN_MAX bits above the start, stopping at the first gap.
    always_comb begin
        shifted  = mask_i >> start_i;
        run_bits = '0;
        cont     = 1'b1;
        count    = '0;
        for (int i = 0; i < RUN_MAX; i++) begin
            if (cont && shifted[i]) begin
                run_bits[i] = 1'b1;
                count       = count + 1'b1;
            end else begin
                cont = 1'b0;
            end
        end
        len_code_o = LW'(count - 1'b1);
        used_o     = W'(run_bits) << start_i;
    end
endmodule

// File: rtl/hit_cluster_encoder.sv
// Module: hit_cluster_encoder
// Encodes one row of column hit flags into up to MAX_STATES cluster states.
// Each state holds a first-column address and a run-length code.
// It emits one state per cycle while busy. Results hold until the next row.
// Assumes that a row is offered only as a strobe and that strobes seen while busy may be dropped.
module hit_cluster_encoder
    import hce_pkg::*;
#(
    parameter int COLS       = 64,
    parameter int MAX_STATES = 6,
    parameter int RUN_MAX    = 4,
    localparam int AW = $clog2(COLS),
    localparam int LW = $clog2(RUN_MAX),
    localparam int CW = $clog2(MAX_STATES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     row_valid_i,
    input  logic [COLS-1:0]          hits_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [MAX_STATES-1:0]    state_valid_o,
    output logic [MAX_STATES*AW-1:0] state_addr_o,
    output logic [MAX_STATES*LW-1:0] state_len_o,
    output logic                     overflow_o
);
    scan_state_e             state_q;
    logic [COLS-1:0]         mask_q;
    logic [CW-1:0]           slot_q;
    logic [MAX_STATES-1:0]   valid_q;
    logic [MAX_STATES*AW-1:0] addr_q;
    logic [MAX_STATES*LW-1:0] len_q;
    logic                    ovf_q;
    logic                    done_q;

    logic                    found;
    logic [AW-1:0]           first_idx;
    logic [LW-1:0]           len_code;
    logic [COLS-1:0]         used;

    hce_first_hit #(.W(COLS)) u_first (
        .mask_i  (mask_q),
        .found_o (found),
        .index_o (first_idx)
    );

    hce_run_len #(.W(COLS), .RUN_MAX(RUN_MAX)) u_run (
        .mask_i     (mask_q),
        .start_i    (first_idx),
        .len_code_o (len_code),
        .used_o     (used)
    );

    // Sequencer: accept a row, emit one state per cycle, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            mask_q  <= '0;
            slot_q  <= '0;
            valid_q <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            ovf_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SCAN_IDLE: begin
                    if (row_valid_i) begin
                        mask_q  <= hits_i;
                        slot_q  <= '0;
                        valid_q <= '0;
                        addr_q  <= '0;
                        len_q   <= '0;
                        ovf_q   <= 1'b0;
                        state_q <= SCAN_RUN;
                    end
                end
                SCAN_RUN: begin
                    if (!found) begin
                        state_q <= SCAN_IDLE;
                        done_q  <= 1'b1;
                    end else if (slot_q == CW'(MAX_STATES)) begin
                        ovf_q   <= 1'b1;
                        state_q <= SCAN_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        for (int s = 0; s < MAX_STATES; s++) begin
                            if (slot_q == CW'(s)) begin
                                valid_q[s]           <= 1'b1;
                                addr_q[s*AW +: AW]   <= first_idx;
                                len_q[s*LW +: LW]    <= len_code;
                            end
                        end
                        mask_q <= mask_q & ~used;
                        slot_q <= slot_q + 1'b1;
                    end
                end
                default: state_q <= SCAN_IDLE;
            endcase
        end
    end

    // Output drive: the registered results.
    always_comb begin
        busy_o        = (state_q == SCAN_RUN);
        done_o        = done_q;
        state_valid_o = valid_q;
        state_addr_o  = addr_q;
        state_len_o   = len_q;
        overflow_o    = ovf_q;
    end
endmodule

// File: rtl/hce_checker.sv
// Module: hce_checker
// Temporal checks on the encoder's ports, attached by bind.
// Assumes that reset is held for at least one edge before rows are offered.
module hce_checker #(
    parameter int COLS       = 64,
    parameter int MAX_STATES = 6,
    parameter int RUN_MAX    = 4,
    localparam int AW = $clog2(COLS),
    localparam int LW = $clog2(RUN_MAX)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     row_valid_i,
    input logic [COLS-1:0]          hits_i,
    input logic                     busy_o,
    input logic                     done_o,
    input logic [MAX_STATES-1:0]    state_valid_o,
    input logic [MAX_STATES*AW-1:0] state_addr_o,
    input logic [MAX_STATES*LW-1:0] state_len_o,
    input logic                     overflow_o
);
    // R7: an accepted strobe makes the block busy on the next cycle.
    a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid_i && !busy_o) |=> busy_o);

    // R8: done is a single-cycle pulse.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done comes exactly when busy falls.
    a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R8: results hold while idle with no new row.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !row_valid_i) |=> ($stable(state_valid_o) && $stable(overflow_o)));

    // R5: filled slots form a block from slot 0 upward.
    a_r5_contig_slots: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_valid_o & (state_valid_o + MAX_STATES'(1))) == '0));

    // R6: overflow only with every slot filled.
    a_r6_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (&state_valid_o));

    // R6: overflow appears only together with done.
    a_r6_overflow_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> done_o);
endmodule

bind hit_cluster_encoder hce_checker #(
    .COLS(COLS), .MAX_STATES(MAX_STATES), .RUN_MAX(RUN_MAX)
) u_hce_checker (
    .clk(clk), .rst_n(rst_n), .row_valid_i(row_valid_i), .hits_i(hits_i),
    .busy_o(busy_o), .done_o(done_o), .state_valid_o(state_valid_o),
    .state_addr_o(state_addr_o), .state_len_o(state_len_o),
    .overflow_o(overflow_o)
);

// File: tb/test_hit_cluster_encoder.sv
// Bench for hit_cluster_encoder: directed corner rows plus seeded random rows.
module test_hit_cluster_encoder;
    localparam int COLS = 64;
    localparam int MS   = 6;
    localparam int AW   = 6;
    localparam int LW   = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               row_valid_i = 1'b0;
    logic [COLS-1:0]    hits_i = '0;
    logic               busy_o, done_o, overflow_o;
    logic [MS-1:0]      state_valid_o;
    logic [MS*AW-1:0]   state_addr_o;
    logic [MS*LW-1:0]   state_len_o;

    int n_tests = 0;
    int n_fail  = 0;

    int exp_addr [MS];
    int exp_len  [MS];
    int exp_n;
    int exp_ovf;

    hit_cluster_encoder i_hit_cluster_encoder (
        .clk(clk), .rst_n(rst_n), .row_valid_i(row_valid_i), .hits_i(hits_i),
        .busy_o(busy_o), .done_o(done_o), .state_valid_o(state_valid_o),
        .state_addr_o(state_addr_o), .state_len_o(state_len_o),
        .overflow_o(overflow_o)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1500000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model built from R1..R6.
    task automatic model(input logic [COLS-1:0] h);
        int c;
        int len;
        exp_n = 0;
        exp_ovf = 0;
        for (int s = 0; s < MS; s++) begin
            exp_addr[s] = 0;
            exp_len[s] = 0;
        end
        c = 0;
        while (c < COLS) begin
            if (h[c]) begin
                len = 1;
                while (len < 4 && c + len < COLS && h[c+len]) len++;
                if (exp_n < MS) begin
                    exp_addr[exp_n] = c;
                    exp_len[exp_n] = len - 1;
                    exp_n++;
                end else begin
                    exp_ovf = 1;
                end
                c += len;
            end else begin
                c++;
            end
        end
    endtask

    // Offer a row, poke a refused strobe while busy, wait for done, compare.
    task automatic run_row(input logic [COLS-1:0] h, input logic [COLS-1:0] junk);
        int waitc;
        model(h);
        @(negedge clk);
        row_valid_i = 1'b1;
        hits_i = h;
        @(negedge clk);
        check(busy_o == 1'b1, "R7 busy after accept", busy_o, 1);
        hits_i = junk;          // R7: strobe while busy must be ignored
        @(negedge clk);
        row_valid_i = 1'b0;
        hits_i = '0;
        waitc = 0;
        while (!done_o && waitc < 200) begin
            @(negedge clk);
            waitc++;
        end
        check(done_o == 1'b1, "R8 done seen", done_o, 1);
        check(busy_o == 1'b0, "R8 idle at done", busy_o, 0);
        for (int s = 0; s < MS; s++) begin
            if (s < exp_n) begin
                check(state_valid_o[s] == 1'b1, "R5 slot valid", state_valid_o[s], 1);
                check(int'(state_addr_o[s*AW +: AW]) == exp_addr[s], "R3 first column",
                      int'(state_addr_o[s*AW +: AW]), exp_addr[s]);
                check(int'(state_len_o[s*LW +: LW]) == exp_len[s], "R2 length code",
                      int'(state_len_o[s*LW +: LW]), exp_len[s]);
                check(h[state_addr_o[s*AW +: AW]] == 1'b1, "R1 address is a hit",
                      int'(h[state_addr_o[s*AW +: AW]]), 1);
            end else begin
                check(state_valid_o[s] == 1'b0, "R1 unused slot invalid", state_valid_o[s], 0);
            end
        end
        check(int'(overflow_o) == exp_ovf, "R6 overflow", overflow_o, exp_ovf);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done one cycle", done_o, 0);
        check(int'($countones(state_valid_o)) == exp_n, "R8 results held",
              $countones(state_valid_o), exp_n);
    endtask

    initial begin
        logic [COLS-1:0] h;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state.
        check(busy_o == 1'b0, "R9 busy reset", busy_o, 0);
        check(done_o == 1'b0, "R9 done reset", done_o, 0);
        check(state_valid_o == '0, "R9 valid reset", state_valid_o, 0);
        check(overflow_o == 1'b0, "R9 overflow reset", overflow_o, 0);
        rst_n = 1'b1;

        // R1: empty row.
        run_row('0, '1);
        // R4: full row, runs cut into groups of four, overflow.
        run_row('1, '0);
        // R4: run of five at column 0 gives (0,11) then (4,00).
        run_row(64'h1F, 64'hF0F0);
        // R2: lengths 1,2,3,4 at distinct places.
        run_row(64'h0000_0F00_7003_0001, '1);
        // R3: run touching the top column.
        run_row(64'hE000_0000_0000_0000, '1);
        run_row(64'h8000_0000_0000_0000, '0);
        // R6: exactly six singletons, no overflow.
        run_row(64'h0000_0555_0000_0000 & 64'h0000_0155_0000_0000 | 64'h1000_0000_0000_0000, '1);
        // R6: seven singletons, overflow.
        run_row(64'h0000_0000_0000_1555, '0);

        // Random rows with varying density (R1..R6).
        for (int k = 0; k < 60; k++) begin
            h = {$urandom, $urandom};
            case (k % 3)
                0: h = h & {$urandom, $urandom} & {$urandom, $urandom};
                1: h = h & {$urandom, $urandom};
                default: h = h | {$urandom, $urandom};
            endcase
            run_row(h, {$urandom, $urandom});
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule